// File: doc/BRIEF.md
# Two-Wire Configuration Memory Target

This block is the target side of a two-wire serial link that lets a host read and write a 256-byte configuration memory. The clock and data lines are sampled inside the system clock domain. The block finds start, stop and repeated-start conditions from the sampled lines. It drives the data line only through an open-drain enable, where a high enable pulls the line low. A host addresses the block with a select byte that holds a 4-bit type code, three strap bits and a read/write flag. After a write select comes a one-byte word address and then any number of data bytes. A read select streams bytes from the current address.

Three strap pins set the block's bus address, so several copies can share one pair of lines. A second type code is reserved for a separate protection block. When a select byte carries that code and matching strap bits, this block does not acknowledge it. Instead it raises a one-cycle decode strobe with the read/write flag. The memory array is gated by an external write-permission input. The current address pointer is brought out so that the permission logic can decide per byte.

Top module: `cfgmem_twi_target`

## Requirements
- R1: The data line is sampled on a rising edge of the serial clock, and the target's drive enable only ever switches on while the serial clock is low, after a falling edge.
- R2: Until a start condition (data falling while the clock is high) is seen, the target ignores all clocked bytes and never drives the data line.
- R3: A stop condition (data rising while the clock is high) releases the data line and returns the target to idle. After reset the drive enable and the decode strobe are low and the pointer is 0x00.
- R4: A select byte, sent MSB first, with bits [7:4] = 1010, bits [3:1] equal to the strap pins and bit 0 as the read flag (1 = read), is acknowledged by pulling data low on the ninth clock. A strap mismatch gets no acknowledge, and the rest of that transaction is ignored.
- R5: A select byte whose type code is neither 1010 nor 0110 is not acknowledged.
- R6: After a write select, the first byte is the word address. Each later byte is acknowledged and stored at the pointer.
- R7: The pointer advances by one after every stored or transmitted byte and wraps from 0xFF to 0x00. Its value is visible on `ptr_o`.
- R8: A read select returns bytes MSB first, starting at the current pointer, and auto-increments.
- R9: A host that does not acknowledge a read byte ends the read. The target then releases the data line until the next start.
- R10: A repeated start (a start with no stop before it) restarts select decoding, so a write of the address followed by a read select reads from that address.
- R11: While `wr_allow_i` is low, a data byte is still acknowledged but the memory is left unchanged.
- R12: A select byte with type code 0110 and matching strap bits is not acknowledged. It raises `prot_sel_o` for exactly one cycle, with `prot_rw_o` holding its bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Bus address strap pins |
| wr_allow_i | input | 1 | High permits writing the addressed byte |
| sda_oe_o | output | 1 | High pulls the data line low |
| ptr_o | output | 8 | Current word address pointer |
| prot_sel_o | output | 1 | One-cycle strobe for a protection-code select |
| prot_rw_o | output | 1 | Read/write flag of the last protection select |

## Verification
A wrong protocol state shows at once as a missing or extra acknowledge on the ninth clock of the byte in question. It can also show as the data line held low after a stop or a host NACK, which the host's next sampled bit exposes. A wrong pointer shows on `ptr_o` right after the byte that should have moved it, and as shifted read data on the next read burst. A write that ignores the permission input, or that lands at the wrong address, only shows when that byte is read back, so every write scenario is followed by a read of the bytes it touched.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  localparam int BYTE_W = 8;
  localparam int BITCNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_ACK_SEL,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sync, sda_sync;
  logic         scl_p, sda_p;

  // The bus idles high, so every stage resets high.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[MSB-1:0], scl_i};
      sda_sync <= {sda_sync[MSB-1:0], sda_i};
      scl_p    <= scl_sync[MSB];
      sda_p    <= sda_sync[MSB];
    end
  end

  assign scl_o      = scl_sync[MSB];
  assign sda_o      = sda_sync[MSB];
  assign scl_rise_o = scl_sync[MSB] & ~scl_p;
  assign scl_fall_o = ~scl_sync[MSB] & scl_p;
  assign start_o    = scl_sync[MSB] & scl_p & sda_p & ~sda_sync[MSB];
  assign stop_o     = scl_sync[MSB] & scl_p & ~sda_p & sda_sync[MSB];
endmodule

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single write port and registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
  import cfgmem_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [3:0] MEM_CODE  = 4'b1010,
  parameter logic [3:0] PROT_CODE = 4'b0110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic              wr_allow_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              prot_sel_o,
  output logic              prot_rw_o
);
  twi_state_e          state_q;
  logic [BITCNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0]   rx_q, tx_q;
  logic [ADDR_W-1:0]   ptr_q;
  logic                rd_mode_q, host_ack_q;

  logic rx_state, byte_done, strap_hit, is_mem, is_prot;

  assign rx_state  = (state_q == ST_SEL) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
  assign byte_done = scl_fall_i && (cnt_q == BITCNT_W'(BYTE_W));
  assign strap_hit = (rx_q[3:1] == strap_i);
  assign is_mem    = (rx_q[7:4] == MEM_CODE) && strap_hit;
  assign is_prot   = (rx_q[7:4] == PROT_CODE) && strap_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      rd_mode_q   <= 1'b0;
      host_ack_q  <= 1'b0;
      sda_oe_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_waddr_o <= '0;
      mem_wdata_o <= '0;
      prot_sel_o  <= 1'b0;
      prot_rw_o   <= 1'b0;
    end else begin
      mem_we_o   <= 1'b0;
      prot_sel_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_SEL;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        if (rx_state && scl_rise_i && (cnt_q < BITCNT_W'(BYTE_W))) begin
          rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + BITCNT_W'(1);
        end
        case (state_q)
          ST_SEL: begin
            if (byte_done) begin
              cnt_q <= '0;
              if (is_mem) begin
                sda_oe_o  <= 1'b1;
                rd_mode_q <= rx_q[0];
                state_q   <= ST_ACK_SEL;
              end else begin
                if (is_prot) begin
                  prot_sel_o <= 1'b1;
                  prot_rw_o  <= rx_q[0];
                end
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR: begin
            if (byte_done) begin
              cnt_q    <= '0;
              ptr_q    <= ADDR_W'(rx_q);
              sda_oe_o <= 1'b1;
              state_q  <= ST_ACK_ADDR;
            end
          end
          ST_WDATA: begin
            if (byte_done) begin
              cnt_q       <= '0;
              mem_we_o    <= wr_allow_i;
              mem_waddr_o <= ptr_q;
              mem_wdata_o <= rx_q;
              ptr_q       <= ptr_q + ADDR_W'(1);
              sda_oe_o    <= 1'b1;
              state_q     <= ST_ACK_WDATA;
            end
          end
          ST_ACK_SEL: begin
            if (scl_fall_i) begin
              if (rd_mode_q) begin
                tx_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                ptr_q    <= ptr_q + ADDR_W'(1);
                cnt_q    <= BITCNT_W'(1);
                state_q  <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_ADDR;
              end
            end
          end
          ST_ACK_ADDR, ST_ACK_WDATA: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (cnt_q == BITCNT_W'(BYTE_W)) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RACK;
              end else begin
                sda_oe_o <= ~tx_q[BYTE_W-2];
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                cnt_q    <= cnt_q + BITCNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) host_ack_q <= ~sda_i;
            if (scl_fall_i) begin
              if (host_ack_q) begin
                tx_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                ptr_q    <= ptr_q + ADDR_W'(1);
                cnt_q    <= BITCNT_W'(1);
                state_q  <= ST_RDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o = ptr_q;

  // R1
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i);

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!sda_oe_o && state_q == ST_IDLE));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R6
  write_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (state_q == ST_ACK_WDATA && sda_oe_o));

  // R12
  prot_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    prot_sel_o |=> !prot_sel_o);
endmodule

// File: rtl/cfgmem_twi_target.sv
module cfgmem_twi_target #(
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] MEM_CODE    = 4'b1010,
  parameter logic [3:0] PROT_CODE   = 4'b0110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              wr_allow_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              prot_sel_o,
  output logic              prot_rw_o
);
  import cfgmem_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic                mem_we;
  logic [ADDR_W-1:0]   mem_waddr;
  logic [BYTE_W-1:0]   mem_wdata, mem_rdata;

  twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  twi_target_fsm #(
    .ADDR_W    (ADDR_W),
    .MEM_CODE  (MEM_CODE),
    .PROT_CODE (PROT_CODE)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_s),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_ev),
    .stop_i      (stop_ev),
    .strap_i     (strap_i),
    .wr_allow_i  (wr_allow_i),
    .rd_data_i   (mem_rdata),
    .sda_oe_o    (sda_oe_o),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata),
    .ptr_o       (ptr_o),
    .prot_sel_o  (prot_sel_o),
    .prot_rw_o   (prot_rw_o)
  );

  cfgmem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (ptr_o),
    .rdata_o (mem_rdata)
  );
endmodule

// File: tb/test_cfgmem_twi_target.sv
`timescale 1ns/1ps
module test_cfgmem_twi_target;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_h = 1'b1;
  logic [2:0] strap = 3'd5;
  logic       wr_allow = 1'b1;
  logic       sda_oe, prot_sel, prot_rw;
  logic [7:0] ptr;
  logic       sda_line;

  int n_chk = 0, n_fail = 0, prot_cnt = 0, r1_viol = 0;
  logic prot_rw_seen = 1'b0, oe_prev = 1'b0;

  assign sda_line = sda_h & ~sda_oe;

  always #4 clk = ~clk;

  cfgmem_twi_target i_cfgmem_twi_target (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .wr_allow_i (wr_allow),
    .sda_oe_o   (sda_oe),
    .ptr_o      (ptr),
    .prot_sel_o (prot_sel),
    .prot_rw_o  (prot_rw)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (prot_sel) begin
        prot_cnt     <= prot_cnt + 1;
        prot_rw_seen <= prot_rw;
      end
      if (sda_oe && !oe_prev && scl) r1_viol <= r1_viol + 1;
    end
    oe_prev <= sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q);
    scl = 1'b1;   tick(2*Q);
    sda_h = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_h = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_h = b;  tick(Q);
    scl = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~host_ack, s);
  endtask

  // Write select at strap 5 = 0xAA, read select = 0xAB.
  task automatic t_reset();
    chk("R3 reset drive enable", sda_oe, 0);
    chk("R3 reset strobe", prot_sel, 0);
    chk("R3 reset pointer", ptr, 8'h00);
  endtask

  task automatic t_no_start();
    logic a;
    send_byte(8'hAA, a);
    chk("R2 select without start ack", a, 0);
    send_byte(8'h10, a);
    chk("R2 second byte without start ack", a, 0);
    bus_stop();
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    send_byte(8'hAA, a); chk("R4 write select ack", a, 1);
    send_byte(8'h10, a); chk("R6 word address ack", a, 1);
    send_byte(8'h11, a); chk("R6 data0 ack", a, 1);
    send_byte(8'h22, a); chk("R6 data1 ack", a, 1);
    send_byte(8'h33, a); chk("R6 data2 ack", a, 1);
    bus_stop();
    chk("R7 pointer after three writes", ptr, 8'h13);
    chk("R3 released after stop", sda_oe, 0);
  endtask

  task automatic t_random_read();
    logic a, s;
    logic [7:0] d;
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte(8'hAB, a); chk("R10 read select after repeated start ack", a, 1);
    recv_byte(1'b1, d); chk("R8 read byte0", d, 8'h11);
    recv_byte(1'b1, d); chk("R8 read byte1", d, 8'h22);
    recv_byte(1'b0, d); chk("R8 read byte2", d, 8'h33);
    clk_bit(1'b1, s);
    chk("R9 line released after host nack", s, 1);
    chk("R9 drive enable low after host nack", sda_oe, 0);
    bus_stop();
    chk("R7 pointer after read", ptr, 8'h13);
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h11, a);
    bus_stop();
    chk("R3 pointer kept across stop", ptr, 8'h11);
    bus_start();
    send_byte(8'hAB, a); chk("R4 read select ack", a, 1);
    recv_byte(1'b0, d); chk("R8 current-address read", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_strap_mismatch();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R4 strap mismatch no ack", a, 0);
    send_byte(8'h10, a); chk("R4 rest of mismatched transfer ignored", a, 0);
    bus_stop();
    chk("R4 pointer untouched by mismatch", ptr, 8'h12);
  endtask

  task automatic t_other_type();
    logic a;
    bus_start();
    send_byte(8'h5A, a); chk("R5 foreign type code no ack", a, 0);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'hFE, a);
    send_byte(8'h77, a);
    send_byte(8'h88, a);
    send_byte(8'h99, a); chk("R6 ack after wrap", a, 1);
    bus_stop();
    chk("R7 pointer wrapped", ptr, 8'h01);
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'hFE, a);
    bus_start();
    send_byte(8'hAB, a);
    recv_byte(1'b1, d); chk("R7 read 0xFE", d, 8'h77);
    recv_byte(1'b1, d); chk("R7 read 0xFF", d, 8'h88);
    recv_byte(1'b0, d); chk("R7 read wrapped 0x00", d, 8'h99);
    bus_stop();
  endtask

  task automatic t_deny();
    logic a;
    logic [7:0] d;
    wr_allow = 1'b0;
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h10, a);
    send_byte(8'h55, a); chk("R11 denied byte still acked", a, 1);
    bus_stop();
    wr_allow = 1'b1;
    chk("R11 pointer still advances", ptr, 8'h11);
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte(8'hAB, a);
    recv_byte(1'b0, d); chk("R11 denied byte unchanged", d, 8'h11);
    bus_stop();
  endtask

  task automatic t_prot();
    logic a;
    int base;
    base = prot_cnt;
    bus_start();
    send_byte(8'h6A, a); chk("R12 protection select no ack", a, 0);
    bus_stop();
    chk("R12 one strobe", prot_cnt - base, 1);
    chk("R12 write flag", prot_rw_seen, 0);
    bus_start();
    send_byte(8'h6B, a);
    bus_stop();
    chk("R12 second strobe", prot_cnt - base, 2);
    chk("R12 read flag", prot_rw_seen, 1);
    bus_start();
    send_byte(8'h60, a);
    bus_stop();
    chk("R12 no strobe on strap mismatch", prot_cnt - base, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung act=1 exp=0");
    summary();
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_no_start();
    t_write_burst();
    t_random_read();
    t_current_read();
    t_strap_mismatch();
    t_other_type();
    t_wrap();
    t_deny();
    t_prot();
    chk("R1 drive switched on while clock high", r1_viol, 0);
    summary();
    $finish;
  end
endmodule